// File: doc/BRIEF.md
# Quad-Channel Serial Converter Write Controller

This block is the receive side of a four-channel, 10-bit converter's serial port. A host selects the block by pulling chip select low and then clocks an instruction header followed by one or more data words into the serial data pin. The header picks a single channel or all four channels. It also says whether the new values should reach the converter registers when chip select is released, or only be staged. Every channel has a staging register that the serial port fills and a converter register that drives the output bus. A dedicated update pin can move all four staged values into the converter registers at once. A sticky interrupt flag shows that the block has come out of reset and has not yet been addressed.

The serial clock, chip select, data and update inputs are asynchronous to the block's system clock. They are synchronised first, and data bits are taken on detected rising edges of the serial clock. The block recognises a header that asks for a readback and signals it to a separate readback unit. It never writes a register for such a header.

Top module: `sdac_wr_ctrl`

## Requirements
- R1: After reset all four converter registers and all four staging registers hold zero, `irq_no` is 0 and `rd_start_o` is 0.
- R2: While chip select is low, any 0 bits clocked in before the first 1 are ignored. That first 1 is the start bit.
- R3: A single-channel header is: start bit, direction bit 0, group bit 0, update bit, then two address bits sent MSB first. Address 0..3 selects channel 0..3. The next 10 bits, sent MSB first, become that channel's staged value. Channel c appears on `dac_o[10*c +: 10]`.
- R4: A group header is: start bit, direction bit 0, group bit 1, update bit, with no address bits. The 10-bit words that follow fill channels 0, 1, 2 and 3 in that order.
- R5: When the update bit is 1, each channel whose word completed is copied from staging to its converter register on the chip-select rising edge. When the update bit is 0, `dac_o` does not change at that edge.
- R6: A falling edge on `upd_ni` while chip select is high copies all four staged values to the converter registers.
- R7: A falling edge on `upd_ni` while chip select is low has no effect on `dac_o`.
- R8: `irq_no` stays 0 from reset until the first chip-select falling edge. It then goes to 1 and stays there.
- R9: A word that is cut short by chip select rising is not staged, and it is not loaded even when the update bit is 1.
- R10: A header with direction bit 1 produces a one-cycle pulse on `rd_start_o`. No register is written by the bits that follow it.
- R11: A group write that ends after two complete words stages and updates channels 0 and 1 only. Channels 2 and 3 keep both their staged and their converter values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low reset (power-up) |
| cs_ni | input | 1 | Chip select, active low, asynchronous |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdi_i | input | 1 | Serial data in |
| upd_ni | input | 1 | Update-all request, falling-edge active, asynchronous |
| dac_o | output | 40 | Four converter register values, channel 0 in the low bits |
| irq_no | output | 1 | Interrupt flag, low after reset until first select |
| rd_start_o | output | 1 | One-cycle pulse when a readback header is recognised |

## Verification
The bench aims at the framing corners: leading zeros before the start bit, a word cut short by chip select, and a group write that ends part way through. A design that counted bits wrongly would stage a shifted or truncated value. A design that staged eagerly would show the partial word after the next update pulse. The bench also checks that the update pin is refused while the chip is selected, and that a readback header leaves every register alone. A design that got the first wrong would move the outputs in the middle of a frame. A design that got the second wrong would treat the read bits as a data word. The deferred-update write is followed by an update pulse, which separates staging from loading.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
    // Receive sequencer phases.
    typedef enum logic [1:0] {
        PH_IDLE, // selected, waiting for the start bit
        PH_HDR,  // collecting header fields
        PH_DATA, // shifting data words
        PH_DONE  // frame finished or handed off; ignore bits
    } rx_phase_e;

    // Header fields after the start bit that are always present:
    // direction, group, update.
    localparam int HDR_FIXED = 3;
endpackage

// File: rtl/sdac_sync.sv
// Multi-stage synchroniser with a one-cycle delayed copy of the low EW bits
// for edge detection.
module sdac_sync #(
    parameter int             W       = 4,
    parameter int             EW      = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [W-1:0]  async_i,
    output logic [W-1:0]  lvl_o,
    output logic [EW-1:0] prv_o
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] chain;
        logic [EW-1:0]            prv;
    } sync_t;

    sync_t d, q;

    always_comb begin
        d          = q;
        d.chain[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            d.chain[s] = q.chain[s-1];
        end
        d.prv = q.chain[STAGES-1][EW-1:0];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q.chain <= {STAGES{RST_VAL}};
            q.prv   <= RST_VAL[EW-1:0];
        end else begin
            q <= d;
        end
    end

    assign lvl_o = q.chain[STAGES-1];
    assign prv_o = q.prv;
endmodule

// File: rtl/sdac_rx.sv
// Header decoder and data word shifter.
module sdac_rx
    import sdac_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 10
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    cs_lvl_i,
    input  logic                    cs_rise_i,
    input  logic                    sclk_rise_i,
    input  logic                    sdi_i,
    output logic                    wr_en_o,
    output logic [$clog2(NCH)-1:0]  wr_ch_o,
    output logic [DW-1:0]           wr_dat_o,
    output logic [NCH-1:0]          ld_mask_o,
    output logic                    rd_start_o
);
    localparam int AW  = $clog2(NCH);
    localparam int CW  = $clog2(DW);
    localparam int HCW = $clog2(HDR_FIXED + AW + 1);
    localparam logic [HCW-1:0] H_RW   = HCW'(0);
    localparam logic [HCW-1:0] H_GRP  = HCW'(1);
    localparam logic [HCW-1:0] H_UPD  = HCW'(2);
    localparam logic [HCW-1:0] H_LAST = HCW'(HDR_FIXED + AW - 1);
    localparam logic [CW-1:0]  D_LAST = CW'(DW - 1);
    localparam logic [AW-1:0]  CH_TOP = AW'(NCH - 1);

    typedef struct packed {
        rx_phase_e      ph;
        logic [HCW-1:0] hcnt;
        logic [CW-1:0]  dcnt;
        logic           grp;
        logic           upd;
        logic [AW-1:0]  ch;
        logic [DW-1:0]  sh;
        logic [NCH-1:0] pend;
        logic           wr_en;
        logic [AW-1:0]  wr_ch;
        logic [DW-1:0]  wr_dat;
        logic [NCH-1:0] ld_mask;
        logic           rd_start;
    } rx_t;

    rx_t d, q;

    always_comb begin
        d          = q;
        d.wr_en    = 1'b0;
        d.ld_mask  = '0;
        d.rd_start = 1'b0;

        if (cs_lvl_i) begin
            // Deselected: drop any frame in progress.
            d.ph   = PH_IDLE;
            d.hcnt = '0;
            d.dcnt = '0;
            if (cs_rise_i) begin
                d.ld_mask = q.pend;
                d.pend    = '0;
            end
        end else if (sclk_rise_i) begin
            unique case (q.ph)
                PH_IDLE: begin
                    if (sdi_i) begin
                        d.ph   = PH_HDR;
                        d.hcnt = '0;
                        d.dcnt = '0;
                        d.grp  = 1'b0;
                        d.upd  = 1'b0;
                        d.ch   = '0;
                    end
                end
                PH_HDR: begin
                    d.hcnt = q.hcnt + 1'b1;
                    if (q.hcnt == H_RW) begin
                        if (sdi_i) begin
                            d.ph       = PH_DONE;
                            d.rd_start = 1'b1;
                        end
                    end else if (q.hcnt == H_GRP) begin
                        d.grp = sdi_i;
                    end else if (q.hcnt == H_UPD) begin
                        d.upd = sdi_i;
                        if (q.grp) begin
                            d.ph = PH_DATA;
                            d.ch = '0;
                        end
                    end else begin
                        d.ch = AW'({q.ch, sdi_i});
                        if (q.hcnt == H_LAST) begin
                            d.ph = PH_DATA;
                        end
                    end
                end
                PH_DATA: begin
                    d.sh   = {q.sh[DW-2:0], sdi_i};
                    d.dcnt = q.dcnt + 1'b1;
                    if (q.dcnt == D_LAST) begin
                        d.dcnt   = '0;
                        d.wr_en  = 1'b1;
                        d.wr_ch  = q.ch;
                        d.wr_dat = {q.sh[DW-2:0], sdi_i};
                        if (q.upd) begin
                            d.pend[q.ch] = 1'b1;
                        end
                        if (q.grp && (q.ch != CH_TOP)) begin
                            d.ch = q.ch + 1'b1;
                        end else begin
                            d.ph = PH_DONE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '{ph: PH_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign wr_en_o    = q.wr_en;
    assign wr_ch_o    = q.wr_ch;
    assign wr_dat_o   = q.wr_dat;
    assign ld_mask_o  = q.ld_mask;
    assign rd_start_o = q.rd_start;
endmodule

// File: rtl/sdac_bank.sv
// Staging and converter registers per channel, plus the interrupt flag.
module sdac_bank #(
    parameter int NCH = 4,
    parameter int DW  = 10
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    wr_en_i,
    input  logic [$clog2(NCH)-1:0]  wr_ch_i,
    input  logic [DW-1:0]           wr_dat_i,
    input  logic [NCH-1:0]          ld_mask_i,
    input  logic                    async_ld_i,
    input  logic                    cs_fall_i,
    output logic [NCH*DW-1:0]       dac_o,
    output logic                    irq_no
);
    typedef struct packed {
        logic [NCH-1:0][DW-1:0] stg;
        logic [NCH-1:0][DW-1:0] cnv;
        logic                   irq_n;
    } bank_t;

    bank_t d, q;

    always_comb begin
        d = q;
        if (wr_en_i) begin
            d.stg[wr_ch_i] = wr_dat_i;
        end
        for (int c = 0; c < NCH; c++) begin
            if (ld_mask_i[c] || async_ld_i) begin
                d.cnv[c] = q.stg[c];
            end
        end
        if (cs_fall_i) begin
            d.irq_n = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_out
        assign dac_o[g*DW +: DW] = q.cnv[g];
    end

    assign irq_no = q.irq_n;
endmodule

// File: rtl/sdac_wr_ctrl.sv
// Top: serial write controller for a quad converter.
module sdac_wr_ctrl #(
    parameter int NCH    = 4,
    parameter int DW     = 10,
    parameter int STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cs_ni,
    input  logic              sclk_i,
    input  logic              sdi_i,
    input  logic              upd_ni,
    output logic [NCH*DW-1:0] dac_o,
    output logic              irq_no,
    output logic              rd_start_o
);
    localparam int AW = $clog2(NCH);
    // Synchroniser bit order: 0 select, 1 serial clock, 2 update, 3 data.
    localparam int BI_CS  = 0;
    localparam int BI_SCK = 1;
    localparam int BI_UPD = 2;
    localparam int BI_SDI = 3;

    logic [3:0]    lvl;
    logic [2:0]    prv;
    logic          cs_lvl, cs_rise, cs_fall, sclk_rise, upd_fall, async_ld;
    logic          wr_en;
    logic [AW-1:0] wr_ch;
    logic [DW-1:0] wr_dat;
    logic [NCH-1:0] ld_mask;

    sdac_sync #(
        .W(4), .EW(3), .STAGES(STAGES), .RST_VAL(4'b0101)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .async_i({sdi_i, upd_ni, sclk_i, cs_ni}),
        .lvl_o  (lvl),
        .prv_o  (prv)
    );

    assign cs_lvl    = lvl[BI_CS];
    assign cs_rise   = lvl[BI_CS] & ~prv[BI_CS];
    assign cs_fall   = ~lvl[BI_CS] & prv[BI_CS];
    assign sclk_rise = lvl[BI_SCK] & ~prv[BI_SCK];
    assign upd_fall  = ~lvl[BI_UPD] & prv[BI_UPD];
    assign async_ld  = upd_fall & cs_lvl;

    sdac_rx #(.NCH(NCH), .DW(DW)) u_rx (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .cs_lvl_i   (cs_lvl),
        .cs_rise_i  (cs_rise),
        .sclk_rise_i(sclk_rise),
        .sdi_i      (lvl[BI_SDI]),
        .wr_en_o    (wr_en),
        .wr_ch_o    (wr_ch),
        .wr_dat_o   (wr_dat),
        .ld_mask_o  (ld_mask),
        .rd_start_o (rd_start_o)
    );

    sdac_bank #(.NCH(NCH), .DW(DW)) u_bank (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en),
        .wr_ch_i   (wr_ch),
        .wr_dat_i  (wr_dat),
        .ld_mask_i (ld_mask),
        .async_ld_i(async_ld),
        .cs_fall_i (cs_fall),
        .dac_o     (dac_o),
        .irq_no    (irq_no)
    );
endmodule

// File: rtl/sdac_chk.sv
// Property checker attached to the top module.
module sdac_chk #(
    parameter int NCH = 4,
    parameter int DW  = 10
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              cs_lvl_i,
    input logic              cs_fall_i,
    input logic              wr_en_i,
    input logic [NCH-1:0]    ld_mask_i,
    input logic              async_ld_i,
    input logic              rd_start_i,
    input logic              irq_ni,
    input logic [NCH*DW-1:0] dac_i
);
    // R5 / R6: converter outputs move only after a load request.
    a_r5_dac_moves_on_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(dac_i) |-> ($past(|ld_mask_i) || $past(async_ld_i)));

    // R5: update-on-release loads only happen while deselected.
    a_r5_load_at_deselect: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|ld_mask_i) |-> $past(cs_lvl_i));

    // R3: staging writes only come from a selected frame.
    a_r3_write_inside_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i |-> !$past(cs_lvl_i));

    // R8: once released, the interrupt flag stays high.
    a_r8_irq_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_ni |=> irq_ni);

    // R8: the flag rises only after a select falling edge.
    a_r8_irq_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_ni) |-> $past(cs_fall_i));

    // R10: a readback handoff never coincides with a staging write.
    a_r10_read_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({rd_start_i, wr_en_i}));
endmodule

bind sdac_wr_ctrl sdac_chk #(.NCH(NCH), .DW(DW)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_lvl_i  (cs_lvl),
    .cs_fall_i (cs_fall),
    .wr_en_i   (wr_en),
    .ld_mask_i (ld_mask),
    .async_ld_i(async_ld),
    .rd_start_i(rd_start_o),
    .irq_ni    (irq_no),
    .dac_i     (dac_o)
);

// File: tb/sim_sdac_wr_ctrl.sv
module sim_sdac_wr_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0, upd_n = 1'b1;
    logic [39:0] dac;
    logic        irq_n, rd_start;

    int tests = 0, failed = 0, rd_cnt = 0;
    bit done = 1'b0;
    logic [9:0] mdl_in  [4];
    logic [9:0] mdl_dac [4];

    always #2.5 clk = ~clk;

    sdac_wr_ctrl u0 (
        .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk),
        .sdi_i(sdi), .upd_ni(upd_n), .dac_o(dac), .irq_no(irq_n),
        .rd_start_o(rd_start)
    );

    always @(negedge clk) if (rd_start) rd_cnt++;

    // {update, channel, data}
    localparam logic [12:0] VEC [6] = '{
        {1'b1, 2'd0, 10'h3FF}, {1'b1, 2'd1, 10'h155}, {1'b1, 2'd2, 10'h2AA},
        {1'b1, 2'd3, 10'h001}, {1'b1, 2'd0, 10'h200}, {1'b1, 2'd3, 10'h000}
    };

    function automatic logic [39:0] flat_dac();
        logic [39:0] v;
        for (int c = 0; c < 4; c++) v[c*10 +: 10] = mdl_dac[c];
        return v;
    endfunction

    task automatic chk(input string req, input logic [39:0] got, input logic [39:0] exp);
        tests++;
        if (got !== exp) begin
            failed++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic sbit(input logic b);
        sdi = b;
        repeat (4) @(negedge clk);
        sclk = 1'b1;
        repeat (4) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic sel();
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic desel();
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic pulse_upd();
        upd_n = 1'b0;
        repeat (8) @(negedge clk);
        upd_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic send_word(input logic [9:0] w, input int nbits);
        for (int i = 9; i > 9 - nbits; i--) sbit(w[i]);
    endtask

    task automatic wr_one(input logic u, input logic [1:0] ch, input logic [9:0] w);
        sel();
        sbit(1); sbit(0); sbit(0); sbit(u); sbit(ch[1]); sbit(ch[0]);
        send_word(w, 10);
        desel();
        mdl_in[ch] = w;
        if (u) mdl_dac[ch] = w;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failed++;
            tests++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, failed);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 4; c++) begin mdl_in[c] = '0; mdl_dac[c] = '0; end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 / R8: reset state
        chk("R1 dac zero", dac, 40'h0);
        chk("R1 rd idle", {39'h0, rd_start}, 40'h0);
        chk("R8 irq low after reset", {39'h0, irq_n}, 40'h0);
        pulse_upd();
        chk("R1 staging zero", dac, 40'h0);

        // R3 / R5: vector table of single-channel writes with update
        for (int k = 0; k < 6; k++) begin
            wr_one(VEC[k][12], VEC[k][11:10], VEC[k][9:0]);
            chk("R3 R5 single write", dac, flat_dac());
        end
        chk("R8 irq set after select", {39'h0, irq_n}, 40'h1);

        // R5: deferred write leaves outputs alone; R6 then loads all
        wr_one(1'b0, 2'd2, 10'h0F0);
        chk("R5 no update", dac, flat_dac());
        pulse_upd();
        for (int c = 0; c < 4; c++) mdl_dac[c] = mdl_in[c];
        chk("R6 async update", dac, flat_dac());

        // R2: leading zeros before the start bit
        sel();
        sbit(0); sbit(0); sbit(0);
        sbit(1); sbit(0); sbit(0); sbit(1); sbit(0); sbit(1);
        send_word(10'h1C3, 10);
        desel();
        mdl_in[1] = 10'h1C3; mdl_dac[1] = 10'h1C3;
        chk("R2 leading zeros", dac, flat_dac());

        // R4: group write with update
        sel();
        sbit(1); sbit(0); sbit(1); sbit(1);
        send_word(10'h011, 10); send_word(10'h122, 10);
        send_word(10'h233, 10); send_word(10'h344, 10);
        desel();
        mdl_in[0] = 10'h011; mdl_in[1] = 10'h122; mdl_in[2] = 10'h233; mdl_in[3] = 10'h344;
        for (int c = 0; c < 4; c++) mdl_dac[c] = mdl_in[c];
        chk("R4 group update", dac, flat_dac());

        // R4 / R6: group write deferred, then async load
        sel();
        sbit(1); sbit(0); sbit(1); sbit(0);
        send_word(10'h3A1, 10); send_word(10'h0B2, 10);
        send_word(10'h1C4, 10); send_word(10'h2D8, 10);
        desel();
        chk("R4 group deferred", dac, flat_dac());
        mdl_in[0] = 10'h3A1; mdl_in[1] = 10'h0B2; mdl_in[2] = 10'h1C4; mdl_in[3] = 10'h2D8;
        pulse_upd();
        for (int c = 0; c < 4; c++) mdl_dac[c] = mdl_in[c];
        chk("R6 group async", dac, flat_dac());

        // R7: update pin while selected is ignored
        wr_one(1'b0, 2'd0, 10'h055);
        sel();
        pulse_upd();
        chk("R7 update while selected", dac, flat_dac());
        desel();
        chk("R7 after release", dac, flat_dac());
        pulse_upd();
        mdl_dac[0] = 10'h055;
        chk("R7 later async", dac, flat_dac());

        // R9: truncated word, update bit set
        sel();
        sbit(1); sbit(0); sbit(0); sbit(1); sbit(1); sbit(1);
        send_word(10'h3FF, 6);
        desel();
        chk("R9 partial not loaded", dac, flat_dac());
        pulse_upd();
        chk("R9 partial not staged", dac, flat_dac());

        // R10: readback header
        sel();
        sbit(1); sbit(1); sbit(0); sbit(0); sbit(0); sbit(1); sbit(0);
        send_word(10'h3FF, 10);
        desel();
        chk("R10 read pulse count", 40'(rd_cnt), 40'd1);
        chk("R10 no dac change", dac, flat_dac());
        pulse_upd();
        chk("R10 no staging write", dac, flat_dac());

        // R11: group write cut after two words
        sel();
        sbit(1); sbit(0); sbit(1); sbit(1);
        send_word(10'h2F0, 10); send_word(10'h10F, 10);
        send_word(10'h3FF, 5);
        desel();
        mdl_in[0] = 10'h2F0; mdl_in[1] = 10'h10F;
        mdl_dac[0] = 10'h2F0; mdl_dac[1] = 10'h10F;
        chk("R11 partial group", dac, flat_dac());
        pulse_upd();
        chk("R11 staging of 2 and 3 kept", dac, flat_dac());
        chk("R8 irq stays high", {39'h0, irq_n}, 40'h1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end
endmodule